// File: doc/BRIEF.md
# Serial-to-Parallel Latched Output Expander

This block turns a three-wire serial stream from a pin-starved controller into a 16-bit parallel output word. The controller presents one bit at a time on a data pin and pulses a shift clock to move it in. When the word is complete, it pulses a latch clock to publish it. The design is built from chained 8-bit shift stages. The top bit of the whole chain is also brought out on a cascade pin, so further expanders can be wired after it.

All three control pins are treated as asynchronous levels. Each passes through a two-flop synchronizer into the system clock domain, and a rising edge is found by comparing the synchronized sample with the one from the cycle before. The shift chain and the published output register each have their own asynchronous active-low clear. The output clear can therefore force the parallel outputs to zero at power-up, before the controller has finished booting and can send anything. Because the three control pins are plain levels that the controller toggles at will, there is no valid/ready handshake: the block never applies back-pressure and accepts every edge it detects.

Top module: `sipo_expander`

## Requirements
- R1: While `hold_clr_n` is low, `par_out` is all zeros. While `chain_clr_n` is low, `cascade_out` is 0.
- R2: Each detected rising edge of `shift_clk` moves every chain bit one place toward bit 15 and puts the synchronized `ser_in` in bit 0. After 16 shift edges, the first bit sent stands on `par_out[15]` once latched.
- R3: `par_out` keeps its value while bits are shifted, for as long as no latch edge is detected.
- R4: A detected rising edge of `latch_clk` copies the whole 16-bit chain into `par_out`.
- R5: Pulling `chain_clr_n` low empties the chain but leaves `par_out` unchanged. A later latch publishes all zeros.
- R6: Pulling `hold_clr_n` low zeros `par_out` but leaves the chain intact. A later latch publishes the chain's contents.
- R7: `cascade_out` always equals bit 15 of the shift chain.
- R8: Bit 7 of the first 8-bit stage feeds bit 0 of the second stage on each shift edge, so a chain holding 16'h0080 holds 16'h0100 after one more shift of a 0.
- R9: When a latch edge and a shift edge are detected in the same system cycle, `par_out` receives the chain value from before that shift.
- R10: A control pin held high counts as one rising edge, however long it stays high.
- R11: A clear that is low wins over any shift or latch edge detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the synchronizers and edge detectors |
| ser_in | input | 1 | Serial data, most significant bit first |
| shift_clk | input | 1 | Shift clock; a rising edge takes in one bit |
| latch_clk | input | 1 | Latch clock; a rising edge publishes the chain |
| chain_clr_n | input | 1 | Active-low asynchronous clear of the shift chain |
| hold_clr_n | input | 1 | Active-low asynchronous clear of the output register |
| par_out | output | 16 | Published parallel word |
| cascade_out | output | 1 | Top bit of the shift chain, for chaining further expanders |

## Verification
The bench loads several words and checks that `par_out` stays frozen until the latch. A design that drove the outputs straight from the chain would show partial words. It clears each stage separately while holding different data in the two stages, which catches a clear wired to the wrong register or to both registers. It raises the shift and latch pins in the same cycle to catch a latch that captures the value after the shift. It holds the shift pin high for many cycles to catch a level-sensitive shift. It also pushes a single bit across the stage boundary to catch a broken link between the 8-bit stages.

// File: rtl/xp_pkg.sv
package xp_pkg;
  // Positions of the control pins inside the synchronized vector
  localparam int unsigned SIG_SER   = 0;
  localparam int unsigned SIG_SHIFT = 1;
  localparam int unsigned SIG_LATCH = 2;
  localparam int unsigned N_SIG     = 3;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flop
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/xp_edge.sv
module xp_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;

  // R10: a level held high yields a single pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/xp_stage.sv
module xp_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         ser_out
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        q <= '0;
    else if (shift_en) q <= {q[W-2:0], ser_in};
  end

  assign ser_out = q[W-1];

  // R2: the incoming bit lands in position 0 and the rest move up
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> (q[0] == $past(ser_in)) && (q[W-1:1] == $past(q[W-2:0])));

  // R2: without a shift edge the stage holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander #(
  parameter int unsigned STAGE_W    = 8,
  parameter int unsigned N_STAGES   = 2,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned TOTAL_W   = STAGE_W * N_STAGES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               shift_clk,
  input  logic               latch_clk,
  input  logic               chain_clr_n,
  input  logic               hold_clr_n,
  output logic [TOTAL_W-1:0] par_out,
  output logic               cascade_out
);
  import xp_pkg::*;

  logic [N_SIG-1:0] raw_pins, sync_pins;
  logic [1:0]       rises;
  logic             shift_rise, latch_rise, ser_sync;
  logic [TOTAL_W-1:0] chain;
  logic [N_STAGES:0]  link;

  assign raw_pins[SIG_SER]   = ser_in;
  assign raw_pins[SIG_SHIFT] = shift_clk;
  assign raw_pins[SIG_LATCH] = latch_clk;

  xp_sync #(.W(N_SIG), .DEPTH(SYNC_DEPTH)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(sync_pins)
  );

  xp_edge #(.W(2)) i_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({sync_pins[SIG_LATCH], sync_pins[SIG_SHIFT]}),
    .rise(rises)
  );

  assign shift_rise = rises[0];
  assign latch_rise = rises[1];
  assign ser_sync   = sync_pins[SIG_SER];
  assign link[0]    = ser_sync;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    xp_stage #(.W(STAGE_W)) i_stage (
      .clk(clk), .clr_n(chain_clr_n), .shift_en(shift_rise),
      .ser_in(link[g]), .q(chain[g*STAGE_W +: STAGE_W]), .ser_out(link[g+1])
    );
  end

  assign cascade_out = link[N_STAGES];

  always_ff @(posedge clk or negedge hold_clr_n) begin
    if (!hold_clr_n)     par_out <= '0;
    else if (latch_rise) par_out <= chain;
  end

  // R3: no latch edge, no change on the outputs
  a_r3_out_frozen: assert property (@(posedge clk) disable iff (!rst_n || !hold_clr_n)
    !latch_rise |=> $stable(par_out));

  // R4 / R9: a latch takes the chain as it stood before that edge
  a_r4_latch_copies: assert property (@(posedge clk) disable iff (!rst_n || !hold_clr_n)
    latch_rise |=> (par_out == $past(chain)));

  // R1 / R6: an output clear holds the word at zero
  a_r6_hold_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_clr_n |-> (par_out == '0));

  // R5 / R11: a chain clear leaves the published word alone
  a_r5_chain_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n || !hold_clr_n)
    (!chain_clr_n && !latch_rise) |=> $stable(par_out));

  // R7: cascade output shows the top chain bit
  a_r7_cascade_top: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_out == chain[TOTAL_W-1]);

  // R8: stage boundaries pass the top bit upward on a shift
  for (genvar b = 1; b < N_STAGES; b++) begin : g_link_chk
    a_r8_stage_link: assert property (@(posedge clk) disable iff (!rst_n || !chain_clr_n)
      shift_rise |=> (chain[b*STAGE_W] == $past(chain[b*STAGE_W-1])));
  end
endmodule

// File: tb/test_sipo_expander.sv
module test_sipo_expander;
  logic        clk = 1'b0;
  logic        rst_n, ser_in, shift_clk, latch_clk, chain_clr_n, hold_clr_n;
  logic [15:0] par_out;
  logic        cascade_out;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  sipo_expander i_sipo_expander (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
    .latch_clk(latch_clk), .chain_clr_n(chain_clr_n), .hold_clr_n(hold_clr_n),
    .par_out(par_out), .cascade_out(cascade_out)
  );

  localparam logic [15:0] WORDS [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                        16'h00FF, 16'hFF00, 16'h1234};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b;
    idle(1); shift_clk = 1'b1;
    idle(4); shift_clk = 1'b0;
    idle(4);
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic do_latch();
    @(negedge clk); latch_clk = 1'b1;
    idle(4); latch_clk = 1'b0;
    idle(4);
  endtask

  initial begin
    rst_n = 0; ser_in = 0; shift_clk = 0; latch_clk = 0;
    chain_clr_n = 0; hold_clr_n = 0;
    idle(3);
    check("R1 reset par_out", par_out, 16'h0000);
    check("R1 reset cascade", {15'd0, cascade_out}, 16'h0000);
    rst_n = 1; chain_clr_n = 1; hold_clr_n = 1;
    idle(2);

    // Table walk: R2, R3, R4, R7
    begin
      logic [15:0] prev_out;
      prev_out = 16'h0000;
      for (int k = 0; k < 6; k++) begin
        shift_word(WORDS[k]);
        check("R3 frozen before latch", par_out, prev_out);
        check("R7 cascade is chain msb", {15'd0, cascade_out}, {15'd0, WORDS[k][15]});
        do_latch();
        check("R2/R4 latched word", par_out, WORDS[k]);
        prev_out = WORDS[k];
      end
    end

    // R8: bit crosses the stage boundary
    shift_word(16'h0080);
    shift_bit(1'b0);
    do_latch();
    check("R8 stage link", par_out, 16'h0100);

    // R5: chain clear leaves outputs, later latch gives zero
    shift_word(16'h5A5A); do_latch();
    shift_bit(1'b1); shift_bit(1'b1);
    @(negedge clk); chain_clr_n = 0; idle(2);
    check("R5 outputs kept", par_out, 16'h5A5A);
    check("R1 cascade during chain clear", {15'd0, cascade_out}, 16'h0000);
    chain_clr_n = 1; idle(2);
    do_latch();
    check("R5 latch after chain clear", par_out, 16'h0000);

    // R6: output clear leaves chain intact
    shift_word(16'hC001); do_latch();
    shift_word(16'h3C3C);
    @(negedge clk); hold_clr_n = 0; idle(2);
    check("R6 outputs zeroed", par_out, 16'h0000);
    hold_clr_n = 1; idle(2);
    check("R6 stays zero until latch", par_out, 16'h0000);
    do_latch();
    check("R6 chain survived", par_out, 16'h3C3C);

    // R10: long-held shift clock shifts once
    @(negedge clk); chain_clr_n = 0; idle(1); chain_clr_n = 1;
    @(negedge clk); ser_in = 1'b1; idle(1);
    shift_clk = 1'b1; idle(30); shift_clk = 1'b0; idle(4);
    ser_in = 1'b0;
    do_latch();
    check("R10 one shift per high level", par_out, 16'h0001);

    // R9: latch and shift edges in the same cycle
    shift_word(16'h0F0F);
    @(negedge clk); ser_in = 1'b1; idle(1);
    shift_clk = 1'b1; latch_clk = 1'b1;
    idle(4); shift_clk = 1'b0; latch_clk = 1'b0; idle(4);
    check("R9 latch takes pre-shift chain", par_out, 16'h0F0F);
    do_latch();
    check("R9 shift still happened", par_out, 16'h1E1F);

    // R11: clear wins over a shift edge in the same window
    shift_word(16'hFFFF);
    @(negedge clk); ser_in = 1'b1; chain_clr_n = 0; shift_clk = 1'b1;
    idle(6); shift_clk = 1'b0; idle(4); chain_clr_n = 1; idle(2);
    do_latch();
    check("R11 chain clear beats shift", par_out, 16'h0000);

    // R11: output clear beats a latch edge
    shift_word(16'hBEEF);
    @(negedge clk); hold_clr_n = 0; latch_clk = 1'b1;
    idle(6); latch_clk = 1'b0; idle(2);
    check("R11 output clear beats latch", par_out, 16'h0000);
    hold_clr_n = 1; idle(2);
    check("R11 no late latch after clear", par_out, 16'h0000);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule